// File: doc/BRIEF.md
# Checkerboard and Gradient Pattern Source

This block turns a stream of video timing strobes into 24-bit test pixels. A separate timing generator supplies the frame strobe (`vs_i`) and the active-pixel qualifier (`de_i`); the block tracks the line and pixel position itself from the edges of these two signals. It then emits either a two-colour checkerboard, a per-line ramp, or all-zero pixels. The output follows the inputs by one register stage.

A small write-only register port holds the configuration. The mode field picks the pattern. Two 24-bit colours and a horizontal run length for each colour set the checkerboard's columns. A line count sets how many lines pass before each line starts with the other colour. An 8-bit step sets the gradient slope. A rising edge on the frame strobe restarts all position state, so every frame is the same.

Top module: `tpg_pixel_source`

## Requirements
- R1: Mode field encoding: 0 gives all-zero pixels, 1 gives the checkerboard, 2 gives the gradient, and 3 is reserved and gives all-zero pixels.
- R2: Register writes with `wr_en_i` high store `wr_data_i` into the addressed register. The addresses are: 0 mode in bits [1:0]; 1 colour A in [23:0]; 2 colour B in [23:0]; 3 colour A run length in [7:0]; 4 colour B run length in [7:0]; 5 line alternation count in [7:0]; 6 gradient step in [7:0]. Colours are packed blue [23:16], green [15:8], red [7:0] and appear on `pix_o` in the same packing.
- R3: In checkerboard mode, each active line starts with the line's start colour. That colour lasts for its own run length, the other colour then lasts for its run length, and the pattern repeats. A run length of 0 acts as 1.
- R4: Counting lines from 0 after the frame strobe rises, line y starts with colour A when floor(y / N) is even and with colour B when it is odd, where N is the alternation count. A count of 0 acts as 1.
- R5: In gradient mode, the pixel at position x of an active line (x = 0 at the rising edge of `de_i`) has each of its three bytes equal to (x * step) mod 256.
- R6: A rising edge of `vs_i` clears the line count and the line phase, so consecutive frames with the same settings are identical.
- R7: `pix_de_o` equals `de_i` delayed by one clock. `pix_o` is all-zero in every cycle that follows a cycle with `de_i` low. The pixel for an input cycle appears on the next clock.
- R8: After reset, both outputs are zero. The register defaults are: mode 0, both colours 0, both run lengths 0x3C, alternation count 0x3C and gradient step 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vs_i | input | 1 | Frame strobe from the timing generator; its rising edge starts a frame |
| de_i | input | 1 | Active-pixel qualifier from the timing generator |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 24 | Register write data |
| pix_o | output | 24 | Pixel value (blue, green, red from high byte to low byte) |
| pix_de_o | output | 1 | Qualifier for `pix_o` |

## Verification
Some behaviour is checked by assertions on every cycle:
- the zero output while `de_i` is low or the mode is off;
- the one-cycle delay of the qualifier;
- the gradient growing by exactly the step between adjacent active pixels;
- the line phase changing only at a line end or a frame start, and being cleared by the frame strobe.

Other behaviour only the bench's frame scenarios can show:
- the full two-dimensional checkerboard layout, meaning which colour lands on which pixel once the run lengths and the alternation count interact;
- zero-valued run lengths;
- the reset defaults;
- frame-to-frame repeatability.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int CH_W   = 8;
  localparam int NCH    = 3;
  localparam int PIX_W  = CH_W * NCH;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    TPG_OFF      = 2'd0,
    TPG_CHECKER  = 2'd1,
    TPG_GRADIENT = 2'd2,
    TPG_RSVD     = 2'd3
  } tpg_mode_e;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COLA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_COLB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RUNA  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RUNB  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ALT   = 3'd5;
  localparam logic [ADDR_W-1:0] A_STEP  = 3'd6;

  localparam logic [CNT_W-1:0] RUN_DEF  = 8'h3C;
  localparam logic [CNT_W-1:0] ALT_DEF  = 8'h3C;
  localparam logic [CH_W-1:0]  STEP_DEF = 8'h10;

  // A programmed count of zero behaves as one.
  function automatic logic [CNT_W:0] eff_len(input logic [CNT_W-1:0] v);
    return (v == '0) ? (CNT_W+1)'(1) : {1'b0, v};
  endfunction

  // Gradient advance, modulo the channel width.
  function automatic logic [CH_W-1:0] grad_next(input logic [CH_W-1:0] v,
                                               input logic [CH_W-1:0] s);
    return v + s;
  endfunction
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  output tpg_mode_e         mode,
  output logic [PIX_W-1:0]  col_a,
  output logic [PIX_W-1:0]  col_b,
  output logic [CNT_W-1:0]  run_a,
  output logic [CNT_W-1:0]  run_b,
  output logic [CNT_W-1:0]  alt,
  output logic [CH_W-1:0]   step
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= TPG_OFF;
      col_a <= '0;
      col_b <= '0;
      run_a <= RUN_DEF;
      run_b <= RUN_DEF;
      alt   <= ALT_DEF;
      step  <= STEP_DEF;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: mode  <= tpg_mode_e'(wr_data[1:0]);
        A_COLA: col_a <= wr_data;
        A_COLB: col_b <= wr_data;
        A_RUNA: run_a <= wr_data[CNT_W-1:0];
        A_RUNB: run_b <= wr_data[CNT_W-1:0];
        A_ALT:  alt   <= wr_data[CNT_W-1:0];
        A_STEP: step  <= wr_data[CH_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tpg_edges.sv
module tpg_edges #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] sig_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) sig_q[i] <= 1'b0;
      else        sig_q[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~sig_q[i];
    assign fall[i] = ~sig[i] & sig_q[i];
  end
endmodule

// File: rtl/tpg_checker_gen.sv
module tpg_checker_gen
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_i,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic             line_end,
  input  logic [PIX_W-1:0] col_a,
  input  logic [PIX_W-1:0] col_b,
  input  logic [CNT_W-1:0] run_a,
  input  logic [CNT_W-1:0] run_b,
  input  logic [CNT_W-1:0] alt,
  output logic [PIX_W-1:0] pix
);
  logic           phase_q;
  logic [CNT_W:0] line_cnt_q;
  logic           sel_q;
  logic [CNT_W:0] run_q;

  logic           sel_now;
  logic [CNT_W:0] idx_now;
  logic [CNT_W:0] len_now;
  logic           run_done;
  logic           phase_flip;

  always_comb begin
    sel_now    = line_start ? phase_q : sel_q;
    idx_now    = line_start ? '0 : run_q;
    len_now    = eff_len(sel_now ? run_b : run_a);
    run_done   = (idx_now + 1'b1) >= len_now;
    phase_flip = (line_cnt_q + 1'b1) >= eff_len(alt);
  end

  assign pix = sel_now ? col_b : col_a;

  // Line phase: which colour each line starts with.
  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      phase_q    <= 1'b0;
      line_cnt_q <= '0;
    end else if (line_end) begin
      if (phase_flip) begin
        phase_q    <= ~phase_q;
        line_cnt_q <= '0;
      end else begin
        line_cnt_q <= line_cnt_q + 1'b1;
      end
    end
  end

  // Horizontal run tracking.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      run_q <= '0;
    end else if (de_i) begin
      if (run_done) begin
        sel_q <= ~sel_now;
        run_q <= '0;
      end else begin
        sel_q <= sel_now;
        run_q <= idx_now + 1'b1;
      end
    end
  end

  AST_PHASE_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> ($past(line_end) || $past(frame_start))); // R4
  AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (phase_q == 1'b0 && line_cnt_q == '0)); // R6
endmodule

// File: rtl/tpg_grad_gen.sv
module tpg_grad_gen
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_i,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic [CH_W-1:0]  step,
  output logic [PIX_W-1:0] pix
);
  logic [CH_W-1:0] g_q;
  logic [CH_W-1:0] g_now;

  assign g_now = line_start ? '0 : g_q;

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) g_q <= '0;
    else if (de_i)             g_q <= grad_next(g_now, step);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pix[c*CH_W +: CH_W] = g_now;
  end

  AST_GRAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (de_i && $past(de_i) && !$past(frame_start)) |->
      (g_now == CH_W'($past(g_now) + $past(step)))); // R5
endmodule

// File: rtl/tpg_pixel_source.sv
module tpg_pixel_source
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs_i,
  input  logic              de_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              pix_de_o
);
  tpg_mode_e        mode;
  logic [PIX_W-1:0] col_a, col_b;
  logic [CNT_W-1:0] run_a, run_b, alt;
  logic [CH_W-1:0]  step;

  logic [1:0] rise, fall;
  logic frame_start, line_start, line_end;
  logic [PIX_W-1:0] chk_pix, grad_pix, sel_pix;

  tpg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .mode(mode), .col_a(col_a), .col_b(col_b),
    .run_a(run_a), .run_b(run_b), .alt(alt), .step(step)
  );

  tpg_edges #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .sig({de_i, vs_i}), .rise(rise), .fall(fall)
  );

  assign frame_start = rise[0];
  assign line_start  = rise[1];
  assign line_end    = fall[1];

  tpg_checker_gen u_chk (
    .clk(clk), .rst_n(rst_n), .de_i(de_i), .frame_start(frame_start),
    .line_start(line_start), .line_end(line_end), .col_a(col_a),
    .col_b(col_b), .run_a(run_a), .run_b(run_b), .alt(alt), .pix(chk_pix)
  );

  tpg_grad_gen u_grad (
    .clk(clk), .rst_n(rst_n), .de_i(de_i), .frame_start(frame_start),
    .line_start(line_start), .step(step), .pix(grad_pix)
  );

  always_comb begin
    case (mode)
      TPG_CHECKER:  sel_pix = chk_pix;
      TPG_GRADIENT: sel_pix = grad_pix;
      default:      sel_pix = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_o    <= '0;
      pix_de_o <= 1'b0;
    end else begin
      pix_o    <= de_i ? sel_pix : '0;
      pix_de_o <= de_i;
    end
  end

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !de_i |=> (pix_o == '0)); // R7
  AST_DE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pix_de_o == $past(de_i))); // R7
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TPG_OFF || mode == TPG_RSVD) |=> (pix_o == '0)); // R1
endmodule

// File: tb/tb_tpg_pixel_source.sv
module tb_tpg_pixel_source;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vs_i = 1'b0, de_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [23:0] wr_data_i = '0;
  logic [23:0] pix_o;
  logic        pix_de_o;

  int n_cmp = 0, n_bad = 0;
  bit pend = 0;
  logic [23:0] pend_e;
  bit pend_de;
  string pend_tag;

  // bench shadow of the configuration
  int m_mode = 0, m_ra = 60, m_rb = 60, m_al = 60, m_st = 16;
  logic [23:0] m_a = 0, m_b = 0;

  tpg_pixel_source dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] exp_chk(int x, int y);
    int ra = (m_ra == 0) ? 1 : m_ra;
    int rb = (m_rb == 0) ? 1 : m_rb;
    int al = (m_al == 0) ? 1 : m_al;
    int r  = x % (ra + rb);
    if (((y / al) % 2) == 0) return (r < ra) ? m_a : m_b;
    return (r < rb) ? m_b : m_a;
  endfunction

  function automatic logic [23:0] exp_grad(int x);
    logic [7:0] g = 8'((x * m_st) % 256);
    return {g, g, g};
  endfunction

  function automatic logic [23:0] exp_pix(int x, int y);
    if (m_mode == 1) return exp_chk(x, y);
    if (m_mode == 2) return exp_grad(x);
    return '0;
  endfunction

  task automatic step(input bit v, input bit d, input logic [23:0] e, input string tag);
    @(negedge clk);
    if (pend) begin
      n_cmp++;
      if (pix_de_o !== pend_de || pix_o !== pend_e) begin
        n_bad++;
        $display("FAIL %s: de=%b pix=%h expected de=%b pix=%h",
                 pend_tag, pix_de_o, pix_o, pend_de, pend_e);
      end
    end
    vs_i = v; de_i = d;
    pend = 1; pend_e = e; pend_de = d; pend_tag = tag;
  endtask

  task automatic wreg(input int a, input logic [23:0] d);
    step(0, 0, '0, "R7");
    wr_en_i = 1; wr_addr_i = 3'(a); wr_data_i = d;
    case (a)
      0: m_mode = int'(d[1:0]);
      1: m_a = d;
      2: m_b = d;
      3: m_ra = int'(d[7:0]);
      4: m_rb = int'(d[7:0]);
      5: m_al = int'(d[7:0]);
      6: m_st = int'(d[7:0]);
      default: ;
    endcase
    step(0, 0, '0, "R2");
    wr_en_i = 0;
  endtask

  task automatic frame(input int w, input int h, input int hb, input string tag);
    step(1, 0, '0, "R7");
    step(1, 0, '0, "R7");
    for (int y = 0; y < h; y++) begin
      for (int k = 0; k < hb; k++) step(0, 0, '0, "R7");
      for (int x = 0; x < w; x++) step(0, 1, exp_pix(x, y), tag);
    end
    step(0, 0, '0, "R7");
    step(0, 0, '0, "R7");
  endtask

  function automatic string mtag();
    if (m_mode == 1) return "R3/R4";
    if (m_mode == 2) return "R5";
    return "R1";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: outputs after reset
    @(negedge clk);
    n_cmp++;
    if (pix_o !== '0 || pix_de_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: pix=%h de=%b expected pix=000000 de=0", pix_o, pix_de_o);
    end
    // R8: default step 0x10, R1: mode 0 gives zero
    frame(20, 2, 3, "R1");
    wreg(0, 24'd2);
    frame(20, 2, 3, "R8");
    // R2: colour byte packing passes straight through
    wreg(1, 24'hFECC00); wreg(2, 24'h006AA7);
    wreg(3, 24'd3); wreg(4, 24'd2); wreg(5, 24'd2);
    wreg(0, 24'd1);
    frame(17, 6, 4, "R3/R4");
    frame(17, 6, 4, "R6");
    // R3/R4: zero counts act as one
    wreg(3, 24'd0); wreg(4, 24'd0); wreg(5, 24'd0);
    frame(9, 4, 2, "R3/R4");
    // R1: reserved mode outputs zero
    wreg(0, 24'd3);
    frame(12, 2, 2, "R1");
    // R5: step wraps modulo 256
    wreg(6, 24'hC7); wreg(0, 24'd2);
    frame(12, 2, 1, "R5");
    // R7: one-pixel lines with one blank cycle
    frame(1, 4, 1, "R7");
    // random configurations
    for (int i = 0; i < 14; i++) begin
      wreg(0, 24'($urandom_range(0, 3)));
      wreg(1, 24'($urandom)); wreg(2, 24'($urandom));
      wreg(3, 24'($urandom_range(0, 6))); wreg(4, 24'($urandom_range(0, 6)));
      wreg(5, 24'($urandom_range(0, 3))); wreg(6, 24'($urandom_range(0, 255)));
      frame($urandom_range(1, 40), $urandom_range(1, 8), $urandom_range(1, 5), mtag());
    end
    step(0, 0, '0, "R7");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule